// File: doc/BRIEF.md
# Warm Reset Clock Safe-Mode Controller

This block decides how the clocks of a processor subsystem react when the reset manager raises a warm reset. It holds four configuration bits that software writes and that only a cold reset clears. From these bits and the warm reset input it drives two sticky safe-mode requests, one for the main clock group and one for the debug clock group. It also drives a select that keeps the debug base clock on the external oscillator, and a flag that tells the boot code to start from on-chip RAM.

The warm reset input arrives asynchronously. It passes through a two-flop synchroniser, and only its rising edge starts a response. A safe-mode request stays set after the warm reset drops. Software releases each group by writing 1 to that group's clear bit. The PLLs, the dividers and the boot code are outside this block and see only its control outputs.

Top module: `wrst_clk_safe_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it rises, cfg_q_o is 0, main_safe_o and dbg_safe_o are 1, and dbg_byp_osc_o and boot_ram_o are 0.
- R2: A cycle with cfg_wr_i high loads cfg_data_i into the configuration, which is read back on cfg_q_o. Bit 0 is the global safe-mode disable, bit 1 the debug safe-mode disable, bit 2 the debug oscillator bypass and bit 3 the warm-boot-from-RAM enable. A warm reset never changes these bits.
- R3: With all configuration bits clear, a rising edge on warm_rst_i sets both main_safe_o and dbg_safe_o at the third rising clock edge after the input rises.
- R4: With bit 0 set, a warm reset leaves main_safe_o unchanged.
- R5: With bit 1 set and bit 2 clear, a warm reset leaves dbg_safe_o unchanged.
- R6: dbg_byp_osc_o equals configuration bit 2 one cycle after the write. While bit 2 is set, a warm reset sets dbg_safe_o even when bit 1 is set.
- R7: At each warm reset edge, boot_ram_o takes the value of bit 3 and then holds it until the next edge. When bit 3 is set, that warm reset sets neither safe-mode request.
- R8: A safe-mode request stays set after warm_rst_i falls. A cycle with clr_wr_i high clears main_safe_o if clr_data_i bit 0 is 1, and clears dbg_safe_o if clr_data_i bit 1 is 1. A warm reset edge in the same cycle wins over the clear.
- R9: A warm reset that stays high produces only one event. A request that is cleared while warm_rst_i is still high stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm reset request from the reset manager, asynchronous, active high |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 4 | Configuration write data |
| clr_wr_i | input | 1 | Safe-mode clear strobe |
| clr_data_i | input | 2 | Write-1-to-clear mask: bit 0 main, bit 1 debug |
| cfg_q_o | output | 4 | Configuration readback |
| main_safe_o | output | 1 | Safe-mode request to the main clock group |
| dbg_safe_o | output | 1 | Safe-mode request to the debug clock group |
| dbg_byp_osc_o | output | 1 | Keeps the debug base clock on the external oscillator |
| boot_ram_o | output | 1 | Boot from on-chip RAM after the last warm reset |

## Verification
The assertions are checked on every cycle. They cover the response to each synchronised warm edge under each configuration, the priority of set over clear, the hold of each request between events, the stability of the configuration outside writes, and the single-pulse edge detector. Some behaviours can only be shown by the bench's scenarios. These are the three-edge latency from the raw asynchronous input, the survival of the configuration across a full warm reset, the absence of a second event while warm reset stays high, and a cold reset that arrives with every bit set.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int NUM_GRP  = 2;
  localparam int GRP_MAIN = 0;
  localparam int GRP_DBG  = 1;

  // bit 0 .. bit 3 in declaration order from the bottom
  typedef struct packed {
    logic boot_ram;
    logic dbg_osc_byp;
    logic dbg_safe_dis;
    logic safe_dis;
  } wrc_cfg_t;

  localparam int CFG_W = $bits(wrc_cfg_t);
endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[i] <= 1'b0;
          else         sh_q[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[i] <= 1'b0;
          else         sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wrc_cfg_reg.sv
module wrc_cfg_reg
  import wrc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output wrc_cfg_t         cfg_o
);
  // cold reset only; warm reset has no path here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (wr_i) cfg_o <= wrc_cfg_t'(data_i);
  end
endmodule

// File: rtl/wrc_policy.sv
module wrc_policy
  import wrc_pkg::*;
(
  input  wrc_cfg_t           cfg_i,
  input  logic               rise_i,
  output logic [NUM_GRP-1:0] set_o
);
  logic quiet;

  // warm boot from RAM: touch no clocks
  assign quiet = cfg_i.boot_ram;

  always_comb begin
    set_o           = '0;
    set_o[GRP_MAIN] = rise_i & ~quiet & ~cfg_i.safe_dis;
    // oscillator bypass overrides the debug disable
    set_o[GRP_DBG]  = rise_i & ~quiet & (~cfg_i.dbg_safe_dis | cfg_i.dbg_osc_byp);
  end
endmodule

// File: rtl/wrc_safe_grp.sv
module wrc_safe_grp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_o <= 1'b1;
    else if (set_i)  req_o <= 1'b1;
    else if (clr_i)  req_o <= 1'b0;
  end
endmodule

// File: rtl/wrst_clk_safe_ctrl.sv
module wrst_clk_safe_ctrl
  import wrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               warm_rst_i,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_data_i,
  input  logic               clr_wr_i,
  input  logic [NUM_GRP-1:0] clr_data_i,
  output logic [CFG_W-1:0]   cfg_q_o,
  output logic               main_safe_o,
  output logic               dbg_safe_o,
  output logic               dbg_byp_osc_o,
  output logic               boot_ram_o
);
  wrc_cfg_t           cfg;
  logic               warm_lvl;
  logic               warm_rise;
  logic [NUM_GRP-1:0] grp_set;
  logic [NUM_GRP-1:0] grp_req;
  logic               boot_q;

  wrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (warm_rst_i),
    .level_o (warm_lvl),
    .rise_o  (warm_rise)
  );

  wrc_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  wrc_policy u_policy (
    .cfg_i  (cfg),
    .rise_i (warm_rise),
    .set_o  (grp_set)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      wrc_safe_grp u_grp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (grp_set[g]),
        .clr_i  (clr_wr_i & clr_data_i[g]),
        .req_o  (grp_req[g])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        boot_q <= 1'b0;
    else if (warm_rise) boot_q <= cfg.boot_ram;
  end

  logic unused_lvl;
  assign unused_lvl = warm_lvl;

  assign cfg_q_o       = cfg;
  assign main_safe_o   = grp_req[GRP_MAIN];
  assign dbg_safe_o    = grp_req[GRP_DBG];
  assign dbg_byp_osc_o = cfg.dbg_osc_byp;
  assign boot_ram_o    = boot_q;
endmodule

// File: rtl/wrc_chk.sv
module wrc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_wr_i,
  input logic [3:0] cfg_data_i,
  input logic       clr_wr_i,
  input logic [1:0] clr_data_i,
  input logic       warm_rise,
  input logic [3:0] cfg_q_o,
  input logic       main_safe_o,
  input logic       dbg_safe_o,
  input logic       dbg_byp_osc_o,
  input logic       boot_ram_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_COLD_STATE: assert (main_safe_o && dbg_safe_o && !dbg_byp_osc_o && !boot_ram_o && cfg_q_o == 4'd0); // R1
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(cfg_q_o)); // R2
  AST_MAIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise && !cfg_q_o[0] && !cfg_q_o[3] |=> main_safe_o); // R3
  AST_MAIN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise && cfg_q_o[0] && !main_safe_o |=> !main_safe_o); // R4
  AST_DBG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise && cfg_q_o[1] && !cfg_q_o[2] && !dbg_safe_o |=> !dbg_safe_o); // R5
  AST_DBG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise && (!cfg_q_o[1] || cfg_q_o[2]) && !cfg_q_o[3] |=> dbg_safe_o); // R6
  AST_BYP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> dbg_byp_osc_o == $past(cfg_data_i[2])); // R6
  AST_BOOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise |=> boot_ram_o == $past(cfg_q_o[3])); // R7
  AST_BOOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_rise |=> $stable(boot_ram_o)); // R7
  AST_QUIET_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise && cfg_q_o[3] && !clr_wr_i && !main_safe_o |=> !main_safe_o); // R7
  AST_CLR_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i && clr_data_i[0] && !warm_rise |=> !main_safe_o); // R8
  AST_CLR_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i && clr_data_i[1] && !warm_rise |=> !dbg_safe_o); // R8
  AST_MAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_rise && !(clr_wr_i && clr_data_i[0]) |=> $stable(main_safe_o)); // R8
  AST_SINGLE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rise |=> !warm_rise); // R9
endmodule

bind wrst_clk_safe_ctrl wrc_chk u_wrc_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_data_i    (cfg_data_i),
  .clr_wr_i      (clr_wr_i),
  .clr_data_i    (clr_data_i),
  .warm_rise     (warm_rise),
  .cfg_q_o       (cfg_q_o),
  .main_safe_o   (main_safe_o),
  .dbg_safe_o    (dbg_safe_o),
  .dbg_byp_osc_o (dbg_byp_osc_o),
  .boot_ram_o    (boot_ram_o)
);

// File: tb/wrst_clk_safe_ctrl_bench.sv
`timescale 1ns/1ps
module wrst_clk_safe_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       warm_rst_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [3:0] cfg_data_i = '0;
  logic       clr_wr_i = 1'b0;
  logic [1:0] clr_data_i = '0;
  logic [3:0] cfg_q_o;
  logic       main_safe_o, dbg_safe_o, dbg_byp_osc_o, boot_ram_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  wrst_clk_safe_ctrl u_wrst_clk_safe_ctrl (
    .clk_i, .rst_ni, .warm_rst_i, .cfg_wr_i, .cfg_data_i, .clr_wr_i, .clr_data_i,
    .cfg_q_o, .main_safe_o, .dbg_safe_o, .dbg_byp_osc_o, .boot_ram_o
  );

  typedef struct {
    string      tag;
    logic       main;
    logic       dbg;
    logic       byp;
    logic       boot;
    logic [3:0] cfg;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;

  // model state
  logic [3:0] m_cfg = '0;
  logic       m_boot = 1'b0;

  task automatic push(string tag, logic main, logic dbg);
    exp_t e;
    e.tag = tag; e.main = main; e.dbg = dbg;
    e.byp = m_cfg[2]; e.boot = m_boot; e.cfg = m_cfg;
    sb_q.push_back(e);
  endtask

  task automatic cmp(string tag, string field, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, field, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      cmp(cur.tag, "main_safe", {3'b0, main_safe_o}, {3'b0, cur.main});
      cmp(cur.tag, "dbg_safe", {3'b0, dbg_safe_o}, {3'b0, cur.dbg});
      cmp(cur.tag, "dbg_byp", {3'b0, dbg_byp_osc_o}, {3'b0, cur.byp});
      cmp(cur.tag, "boot_ram", {3'b0, boot_ram_o}, {3'b0, cur.boot});
      cmp(cur.tag, "cfg", cfg_q_o, cur.cfg);
    end
  end

  task automatic wr_cfg(logic [3:0] v);
    @(negedge clk_i); cfg_wr_i = 1'b1; cfg_data_i = v;
    @(posedge clk_i); m_cfg = v;
    @(negedge clk_i); cfg_wr_i = 1'b0;
  endtask

  task automatic wr_clr(logic [1:0] v);
    @(negedge clk_i); clr_wr_i = 1'b1; clr_data_i = v;
    @(posedge clk_i);
    @(negedge clk_i); clr_wr_i = 1'b0; clr_data_i = '0;
  endtask

  // raise warm reset; response lands on the third edge
  task automatic warm_up;
    @(negedge clk_i); warm_rst_i = 1'b1;
    repeat (3) @(posedge clk_i);
    m_boot = m_cfg[3];
  endtask

  task automatic warm_down;
    @(negedge clk_i); warm_rst_i = 1'b0;
    repeat (4) @(posedge clk_i);
  endtask

  task automatic settle;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    settle();
    push("R1 in reset", 1, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i);
    push("R1 after release", 1, 1);

    wr_clr(2'b11);
    push("R8 clear both", 0, 0);

    warm_up();
    push("R3 default warm", 1, 1);
    wr_clr(2'b11);
    repeat (6) @(posedge clk_i);
    push("R9 no second event while high", 0, 0);
    warm_down();
    push("R8 cleared state held after fall", 0, 0);

    warm_up();
    warm_down();
    push("R8 requests held after fall", 1, 1);
    wr_clr(2'b01);
    push("R8 clear main only", 0, 1);
    wr_clr(2'b10);

    wr_cfg(4'b0001);
    push("R2 cfg readback", 0, 0);
    warm_up();
    push("R4 main kept with global disable", 0, 1);
    warm_down();
    push("R2 cfg survives warm", 0, 1);
    wr_clr(2'b11);

    wr_cfg(4'b0010);
    warm_up();
    push("R5 dbg kept with debug disable", 1, 0);
    warm_down();
    wr_clr(2'b11);

    wr_cfg(4'b0110);
    push("R6 bypass follows cfg", 0, 0);
    warm_up();
    push("R6 bypass overrides debug disable", 1, 1);
    warm_down();
    wr_clr(2'b11);

    wr_cfg(4'b1000);
    warm_up();
    push("R7 warm boot RAM no clock change", 0, 0);
    warm_down();
    push("R7 boot flag held", 0, 0);

    wr_cfg(4'b0000);
    push("R7 boot flag unchanged by cfg write", 0, 0);
    warm_up();
    push("R7 boot flag cleared at next warm", 1, 1);
    warm_down();

    // set wins over clear in the same cycle: clear lands on the rise cycle
    wr_clr(2'b11);
    @(negedge clk_i); warm_rst_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i); clr_wr_i = 1'b1; clr_data_i = 2'b11;
    @(posedge clk_i);
    @(negedge clk_i); clr_wr_i = 1'b0; clr_data_i = '0;
    push("R8 set wins over clear", 1, 1);
    warm_down();

    wr_cfg(4'b1111);
    wr_clr(2'b11);
    @(negedge clk_i); rst_ni = 1'b0;
    m_cfg = '0; m_boot = 1'b0;
    @(posedge clk_i);
    push("R1 cold reset with all bits set", 1, 1);
    @(negedge clk_i); rst_ni = 1'b1;

    settle();
    settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule